// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out Gate

This block copies one reference clock onto eighteen outputs. Each output has its own enable bit. A two-wire serial bus with start and stop framing, as used by I2C, programs the enable bits. The block only receives on this bus. It holds three 8-bit enable registers. A write transaction fills them strictly in order, starting from the first register after every START. There is no register index byte, and the block never returns data.

An output whose bit is 1 passes the reference clock. An output whose bit is 0 is held low. Each bit change is carried into the reference clock domain and applied only while the reference clock is low, so an output never produces a shortened pulse. A global active-high output-enable pin marks every output as high impedance when it is low. A system clock oversamples SCL and SDA through two-flop synchronisers. SDA is driven open-drain through a pull-low enable.

Top module: `clkfan_i2c_gate`

## Requirements
- R1: While reset is asserted, and after it is released, every stored enable bit is 1 and every output follows the reference clock.
- R2: The block acknowledges (pulls SDA low during the ninth SCL pulse) a header byte whose upper 7 bits equal DEV_ADDR and whose bit 0 is 0. It gives no acknowledge to any other address or to a read request, and such a transaction changes no output.
- R3: Each data byte of an acknowledged write is acknowledged. The first, second and third bytes land in register 0, register 1 and register 2 respectively.
- R4: Every START, including a repeated START, sends the next data byte to register 0.
- R5: Data bytes after the third in one transaction are acknowledged and change nothing.
- R6: Bits 0..7 of register 0 drive outputs 0..7, and bits 0..7 of register 1 drive outputs 8..15. Bits 0..1 of register 2 drive outputs 16..17, and bits 2..7 of register 2 have no effect on any output.
- R7: An output whose bit is 0 stays low. An output whose bit is 1 equals the reference clock.
- R8: clk_out_oe is all ones when out_en is 1 and all zeros when out_en is 0, whatever the register contents.
- R9: An output's gating changes only while the reference clock is low, so every high phase of an output is a full reference high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock used to oversample the serial bus |
| sys_rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock copied to all outputs |
| out_en | input | 1 | Global output enable, active high |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_o | output | 1 | Data value for the open-drain pad, always 0 |
| sda_oe | output | 1 | Pull SDA low when 1 (acknowledge) |
| clk_out | output | 18 | Gated copies of ref_clk |
| clk_out_oe | output | 18 | Per-output drive enable; 0 means high impedance |

## Verification
The bench targets several specific faults. The first is a wrong or read header. A design that acknowledged it would pull SDA and would overwrite enables. The second is a repeated START in the middle of a transaction. A pointer that does not restart would put the new byte in register 1. The third is a transaction longer than three bytes. A pointer that wraps would overwrite register 0, and the bench detects this as outputs switching off. The bench also writes the six spare bits of register 2 to check that they reach no output. It measures each high phase of every output, because gating applied on the wrong edge would produce pulses that differ from the reference high phase.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_DATA,
    RX_DATA_ACK
  } rx_state_t;

  // Header byte selects this device for a write.
  function automatic logic hdr_selects(logic [7:0] hdr, logic [6:0] own);
    return (hdr[7:1] == own) && !hdr[0];
  endfunction

  // Number of 8-bit registers needed for a given output count.
  function automatic int regs_for(int outs);
    return (outs + 7) / 8;
  endfunction

endpackage

// File: rtl/clkfan_bus_sync.sv
module clkfan_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkfan_wr_rx.sv
module clkfan_wr_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  output logic       sda_pull,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       addr_hit
);
  rx_state_t  st;
  logic [3:0] nbits;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      nbits    <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_byte  <= '0;
      addr_hit <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      addr_hit <= 1'b0;
      if (start_evt) begin
        st       <= RX_ADDR;
        nbits    <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        st       <= RX_IDLE;
        nbits    <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && nbits != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              nbits <= nbits + 4'd1;
            end else if (scl_fall && nbits == 4'd8) begin
              nbits <= '0;
              if (st == RX_DATA) begin
                sda_pull <= 1'b1;
                wr_stb   <= 1'b1;
                wr_byte  <= shreg;
                st       <= RX_DATA_ACK;
              end else if (hdr_selects(shreg, DEV_ADDR)) begin
                sda_pull <= 1'b1;
                addr_hit <= 1'b1;
                st       <= RX_ADDR_ACK;
              end else begin
                st <= RX_IDLE;
              end
            end
          end
          RX_ADDR_ACK, RX_DATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              st       <= RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkfan_en_regs.sv
module clkfan_en_regs #(
  parameter int NUM_REGS = 3,
  parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_evt,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_byte,
  output logic [PTR_W-1:0]      reg_ptr,
  output logic [NUM_REGS*8-1:0] reg_bits
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ptr  <= '0;
      reg_bits <= '1;
    end else if (start_evt) begin
      reg_ptr <= '0;
    end else if (wr_stb && reg_ptr < PTR_END) begin
      reg_bits[int'(reg_ptr)*8 +: 8] <= wr_byte;
      reg_ptr <= reg_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/clkfan_gate_bank.sv
module clkfan_gate_bank #(
  parameter int NUM_OUT = 18,
  parameter int SYNC    = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_vec,
  input  logic               out_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_oe,
  output logic [NUM_OUT-1:0] gate_q
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic [SYNC-1:0] sync_q;
    logic            hold_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC-2:0], en_vec[g]};
    end

    // Updated on the falling edge: the change lands while ref_clk is low.
    always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b1;
      else        hold_q <= sync_q[SYNC-1];
    end

    assign gate_q[g]     = hold_q;
    assign clk_out[g]    = ref_clk & hold_q;
    assign clk_out_oe[g] = out_en;
  end
endmodule

// File: rtl/clkfan_i2c_gate.sv
module clkfan_i2c_gate
  import clkfan_pkg::*;
#(
  parameter int         NUM_OUT  = 18,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC     = 2
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               ref_clk,
  input  logic               out_en,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_oe
);
  localparam int NUM_REGS = regs_for(NUM_OUT);
  localparam int PTR_W    = $clog2(NUM_REGS + 1);

  logic                  scl_s, sda_s, scl_rise, scl_fall;
  logic                  start_evt, stop_evt;
  logic                  wr_stb, addr_hit;
  logic [7:0]            wr_byte;
  logic [PTR_W-1:0]      reg_ptr;
  logic [NUM_REGS*8-1:0] reg_bits;
  logic [NUM_OUT-1:0]    en_vec, gate_q;

  clkfan_bus_sync #(.STAGES(SYNC)) u_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  clkfan_wr_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(sys_clk), .rst_n(sys_rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_pull(sda_oe), .wr_stb(wr_stb), .wr_byte(wr_byte), .addr_hit(addr_hit)
  );

  clkfan_en_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(sys_clk), .rst_n(sys_rst_n), .start_evt(start_evt),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .reg_ptr(reg_ptr), .reg_bits(reg_bits)
  );

  assign en_vec = reg_bits[NUM_OUT-1:0];

  clkfan_gate_bank #(.NUM_OUT(NUM_OUT), .SYNC(SYNC)) u_gate (
    .ref_clk(ref_clk), .rst_n(sys_rst_n), .en_vec(en_vec), .out_en(out_en),
    .clk_out(clk_out), .clk_out_oe(clk_out_oe), .gate_q(gate_q)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int NUM_OUT  = 18,
  parameter int NUM_REGS = 3,
  parameter int PTR_W    = 2
) (
  input logic                  sys_clk,
  input logic                  sys_rst_n,
  input logic                  ref_clk,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  start_evt,
  input logic                  wr_stb,
  input logic                  addr_hit,
  input logic [PTR_W-1:0]      reg_ptr,
  input logic [NUM_REGS*8-1:0] reg_bits,
  input logic [NUM_OUT-1:0]    gate_q
);
  logic [NUM_OUT-1:0] gate_at_rise;

  always_ff @(posedge ref_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) gate_at_rise <= '1;
    else            gate_at_rise <= gate_q;
  end

  // R1
  reset_default_chk: assert property (@(posedge sys_clk)
    !sys_rst_n |-> (&reg_bits));

  // R2
  ack_on_low_scl_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2
  addr_ack_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    addr_hit |-> sda_oe);

  // R3
  data_ack_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wr_stb |-> sda_oe);

  // R4
  ptr_restart_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    start_evt |=> (reg_ptr == '0));

  // R5
  no_spill_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_stb && reg_ptr == PTR_W'(NUM_REGS)) |=> $stable(reg_bits));

  // R9
  gate_hold_chk: assert property (@(negedge ref_clk) disable iff (!sys_rst_n)
    gate_q == gate_at_rise);
endmodule

bind clkfan_i2c_gate clkfan_chk #(
  .NUM_OUT(NUM_OUT), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)
) u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ref_clk(ref_clk),
  .scl_s(scl_s), .sda_oe(sda_oe), .start_evt(start_evt), .wr_stb(wr_stb),
  .addr_hit(addr_hit), .reg_ptr(reg_ptr), .reg_bits(reg_bits), .gate_q(gate_q)
);

// File: tb/test_clkfan_i2c_gate.sv
`timescale 1ns/1ps
module test_clkfan_i2c_gate;
  localparam int         NOUT = 18;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 200;

  logic sys_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic sys_rst_n = 1'b1;
  logic out_en = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_o, sda_oe;
  logic [NOUT-1:0] clk_out, clk_out_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, runts = 0;
  logic [23:0] exp_store = '1;
  logic [7:0]  data_q [0:7];

  always #10 sys_clk = ~sys_clk;
  initial begin #7; forever #20 ref_clk = ~ref_clk; end

  clkfan_i2c_gate #(.NUM_OUT(NOUT), .DEV_ADDR(ADDR)) i_clkfan_i2c_gate (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ref_clk(ref_clk), .out_en(out_en),
    .scl_i(m_scl), .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe),
    .clk_out(clk_out), .clk_out_oe(clk_out_oe)
  );

  function automatic logic hdr_ok(logic [7:0] h);
    return h[7:1] == ADDR && h[0] == 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R9 monitor: each output must not change within one reference high phase.
  initial begin
    forever begin
      @(posedge ref_clk);
      #2;
      begin
        logic [NOUT-1:0] a;
        a = clk_out;
        #16;
        if (sys_rst_n && a !== clk_out) runts++;
      end
    end
  end

  task automatic i2c_start();
    m_sda = 1; #Q; m_scl = 1; #Q; m_sda = 0; #Q; m_scl = 0; #Q;
  endtask
  task automatic i2c_stop();
    m_sda = 0; #Q; m_scl = 1; #Q; m_sda = 1; #Q;
  endtask
  task automatic send_bit(input logic b, output logic rd);
    m_sda = b; #Q; m_scl = 1; #Q; rd = sda_line; #Q; m_scl = 0; #Q;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int k = 7; k >= 0; k--) send_bit(b[k], r);
    send_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic xfer(input logic [7:0] hdr, input int n, input bit keep_open);
    logic ack;
    int p;
    i2c_start();
    p = 0;
    send_byte(hdr, ack);
    chk(ack == hdr_ok(hdr), "R2 header ack", 32'(ack), 32'(hdr_ok(hdr)));
    if (ack) begin
      for (int k = 0; k < n; k++) begin
        send_byte(data_q[k], ack);
        chk(ack == 1'b1, (p < 3) ? "R3 data ack" : "R5 extra byte ack", 32'(ack), 32'd1);
        if (p < 3) begin
          exp_store[p*8 +: 8] = data_q[k];
          p++;
        end
      end
    end
    if (!keep_open) i2c_stop();
  endtask

  task automatic check_outputs(input string req);
    repeat (8) @(posedge ref_clk);
    #5;
    chk(clk_out === exp_store[NOUT-1:0], req, 32'(clk_out), 32'(exp_store[NOUT-1:0]));
    chk(clk_out_oe === {NOUT{out_en}}, "R8 oe follows out_en", 32'(clk_out_oe), 32'({NOUT{out_en}}));
    @(negedge ref_clk);
    #5;
    chk(clk_out === '0, "R7 low phase", 32'(clk_out), 32'd0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1 sys_rst_n = 1'b0;
    #100;
    // R1 during reset
    chk(clk_out_oe === '1, "R1 oe in reset", 32'(clk_out_oe), 32'h3ffff);
    sys_rst_n = 1'b1;
    check_outputs("R1 reset default all enabled");

    // R8 out_en low
    out_en = 1'b0; #3;
    chk(clk_out_oe === '0, "R8 out_en low", 32'(clk_out_oe), 32'd0);
    out_en = 1'b1; #3;
    chk(clk_out_oe === '1, "R8 out_en high", 32'(clk_out_oe), 32'h3ffff);

    // R7 all disabled
    data_q[0] = 8'h00; data_q[1] = 8'h00; data_q[2] = 8'h00;
    xfer({ADDR, 1'b0}, 3, 0);
    check_outputs("R7 all disabled");
    out_en = 1'b0;
    check_outputs("R8 oe low with disabled bits");
    out_en = 1'b1;

    // R6 mapping
    data_q[0] = 8'hA5; data_q[1] = 8'h3C; data_q[2] = 8'hFE;
    xfer({ADDR, 1'b0}, 3, 0);
    check_outputs("R6 bit to output mapping");

    // R5 extra bytes ignored
    data_q[0] = 8'hFF; data_q[1] = 8'hFF; data_q[2] = 8'h03;
    data_q[3] = 8'h00; data_q[4] = 8'h00;
    xfer({ADDR, 1'b0}, 5, 0);
    check_outputs("R5 extra bytes ignored");

    // R2 wrong address and read request
    data_q[0] = 8'h00;
    xfer({ADDR ^ 7'h11, 1'b0}, 1, 0);
    check_outputs("R2 wrong address no effect");
    xfer({ADDR, 1'b1}, 1, 0);
    check_outputs("R2 read request no effect");

    // R4 repeated start resets pointer
    data_q[0] = 8'h00;
    xfer({ADDR, 1'b0}, 1, 1);
    data_q[0] = 8'h0F;
    xfer({ADDR, 1'b0}, 1, 0);
    check_outputs("R4 repeated start back to register 0");

    // R6 spare bits of register 2
    data_q[0] = 8'hFF; data_q[1] = 8'hFF; data_q[2] = 8'hFC;
    xfer({ADDR, 1'b0}, 3, 0);
    check_outputs("R6 outputs 16 and 17 low");
    data_q[2] = 8'h03;
    xfer({ADDR, 1'b0}, 3, 0);
    check_outputs("R6 spare bits no effect");

    // Random transactions
    for (int t = 0; t < 20; t++) begin
      int sel, n;
      logic [7:0] hdr;
      sel = $urandom % 8;
      n   = $urandom % 6;
      for (int k = 0; k < 8; k++) data_q[k] = 8'($urandom);
      if (sel == 0)      hdr = {ADDR ^ 7'(1 + $urandom % 127), 1'b0};
      else if (sel == 1) hdr = {ADDR, 1'b1};
      else               hdr = {ADDR, 1'b0};
      xfer(hdr, n, 0);
      check_outputs("R3 R6 random write");
    end

    chk(runts == 0, "R9 no runt pulses", 32'(runts), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule